// File: doc/BRIEF.md
# UART Receive Byte Queue

This block holds received bytes for a memory-mapped serial port between the moment the deserialiser delivers them and the moment software reads them. On the serial side it accepts a byte with a valid strobe and a separate break indication. On the register side it offers a pop-style data read, a write to a small control register and a combinational status word. It keeps an occupancy count, a full flag, a data-ready flag and a four-bit error register that clears when it is read. Overflow and underflow events go out as a one-cycle pulse to a separate interrupt block.

With queue mode enabled, bytes pass through a circular buffer whose depth is a parameter. With queue mode disabled, a single holding register takes each new byte and overwrites the previous one. The control register also carries two self-clearing flush commands. One empties the receive queue. The other is passed out as a one-cycle pulse to the transmit side.

Top module: `rxq_top`

## Requirements
- R1: After reset the count is 0, the status word is 0, data_ready is 0, err_status is 0, ctl_q is 0, err_evt is 0 and tx_flush is 0.
- R2: In queue mode (ctl_q[0]=1), bytes are read in arrival order, including after the pointers wrap past DEPTH entries. rd_byte shows the oldest byte in the cycle rd_pop is high, and the byte leaves the queue at that clock edge.
- R3: stat_word[7:0] holds the occupancy and stat_word[8] the full flag. When the queue holds DEPTH bytes, stat_word reads 9'h100: the count field is zero and the full bit is one.
- R4: In queue mode, a byte pushed while the queue is full and no pop occurs is dropped, leaving the contents unchanged. err_evt is high for the single cycle after that edge, and err_status bit 0 (overrun) is set.
- R5: In queue mode, rd_pop on an empty queue with no push in the same cycle returns 0x00 on rd_byte, leaves the count at 0, and raises err_evt for the next cycle.
- R6: In queue mode, a push and a pop in the same cycle leave the count unchanged and never raise err_evt. If the queue is empty, the incoming byte appears on rd_byte directly.
- R7: rx_break pushes a 0x00 byte in place of rx_byte, even when rx_valid is also high, and sets err_status bit 3 (break).
- R8: err_rd clears err_status to zero at the next edge. An overrun or break in the same cycle still sets its bit. Bits 1 (parity) and 2 (frame) always read zero.
- R9: In queue mode, data_ready is set by any receive. It stays set while bytes remain, and it clears at the edge where a pop removes the last byte or a receive flush takes effect.
- R10: With ctl_q[0]=0, a receive overwrites the holding register and sets data_ready. rd_pop returns the holding register and clears data_ready, unless a receive arrives in the same cycle. The queue contents are not touched and err_evt stays low.
- R11: A control write stores ctl_wdata into ctl_q (bit 0 queue enable, bit 1 receive flush, bit 2 transmit flush). Bits 1 and 2 read as one for exactly one cycle and then clear. While bit 1 is set, that cycle's queue push or pop is ignored, and the count is 0 at the following edge. tx_flush equals ctl_q[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received data byte |
| rx_break | input | 1 | Break condition detected on the line |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 3 | Control write data: enable, receive flush, transmit flush |
| ctl_q | output | 3 | Current control register contents |
| tx_flush | output | 1 | One-cycle transmit flush command |
| rd_pop | input | 1 | Data read strobe; removes one byte |
| rd_byte | output | 8 | Data returned for the read in this cycle |
| stat_word | output | 9 | Occupancy count [7:0] and full flag [8] |
| data_ready | output | 1 | Received data is available |
| err_rd | input | 1 | Read strobe of the error register; clears it |
| err_status | output | 4 | Error flags: overrun bit 0, parity bit 1, frame bit 2, break bit 3 |
| err_evt | output | 1 | One-cycle overflow/underflow event for the interrupt block |

## Verification
The bench targets the full boundary. It checks that the status word reads 0x100 rather than wrapping the count to 0 with no full flag. It checks that an extra byte is dropped instead of overwriting the oldest entry. A design that got this wrong would hand software a corrupted queue or an impossible status. It also checks the empty boundary: an underflow read must return zero and pulse the error event, and a same-cycle push and pop on an empty queue must bypass the byte without a false underflow. Further checks cover pointer wraparound after many fill and drain rounds, a flush landing in the same cycle as traffic, a break colliding with a valid byte, and an error-register read racing a new event. In each of these cases a careless design would lose the event or keep a stale bit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CTL_W    = 3;
  localparam int unsigned ERR_W    = 4;
  localparam int unsigned STAT_W   = 9;
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_RXFL = 1;
  localparam int unsigned CTL_TXFL = 2;
  localparam int unsigned ERR_OVR  = 0;
  localparam int unsigned ERR_PAR  = 1;
  localparam int unsigned ERR_FRM  = 2;
  localparam int unsigned ERR_BRK  = 3;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic pop,
  input  byte_t wdata,
  output byte_t head,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
  output logic empty,
  output logic full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH-1);

  byte_t         mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = (wp_q == PLAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_d = (rp_q == PLAST) ? '0 : rp_q + 1'b1;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= wdata;
  end

  assign head    = mem[rp_q];
  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovr,
  input  logic set_brk,
  input  logic rd_clr,
  output logic [ERR_W-1:0] err_q
);
  logic [ERR_W-1:0] err_r, err_d;

  always_comb begin
    err_d = rd_clr ? '0 : err_r;
    if (set_ovr) err_d[ERR_OVR] = 1'b1;
    if (set_brk) err_d[ERR_BRK] = 1'b1;
    err_d[ERR_PAR] = 1'b0;
    err_d[ERR_FRM] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_r <= '0;
    else        err_r <= err_d;
  end

  assign err_q = err_r;

  // R8
  clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_ovr && !set_brk) |=> (err_q == '0));
endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl
);
  logic [CTL_W-1:0] ctl_r, ctl_d;

  always_comb begin
    ctl_d = ctl_r;
    ctl_d[CTL_RXFL] = 1'b0;
    ctl_d[CTL_TXFL] = 1'b0;
    if (we) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_r <= '0;
    else        ctl_r <= ctl_d;
  end

  assign ctl = ctl_r;

  // R11
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_r[CTL_RXFL] && !we) |=> !ctl_r[CTL_RXFL]);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_break,
  input  logic       ctl_we,
  input  logic [2:0] ctl_wdata,
  output logic [2:0] ctl_q,
  output logic       tx_flush,
  input  logic       rd_pop,
  output logic [7:0] rd_byte,
  output logic [8:0] stat_word,
  output logic       data_ready,
  input  logic       err_rd,
  output logic [3:0] err_status,
  output logic       err_evt
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic  empty, full, q_mode, flush;
  logic  push, push_eff, pop_eff, ring_push, ring_pop;
  logic  ovf, unf;
  byte_t pdat, head, hold_q, hold_d;
  logic  rdy_q, rdy_d, evt_q, evt_d;

  rxq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl_q)
  );

  assign q_mode   = ctl_q[CTL_EN];
  assign flush    = ctl_q[CTL_RXFL];
  assign tx_flush = ctl_q[CTL_TXFL];

  assign push     = rx_valid | rx_break;
  assign pdat     = rx_break ? '0 : rx_byte;
  assign push_eff = q_mode & push & ~flush;
  assign pop_eff  = q_mode & rd_pop & ~flush;

  assign ring_pop  = pop_eff & ~empty;
  assign ring_push = push_eff & ~(pop_eff & empty) & (~full | pop_eff);
  assign ovf       = push_eff & full & ~pop_eff;
  assign unf       = pop_eff & empty & ~push_eff;

  rxq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(ring_push), .pop(ring_pop),
    .wdata(pdat), .head(head), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .empty(empty), .full(full)
  );

  rxq_errstat u_err (
    .clk(clk), .rst_n(rst_n), .set_ovr(ovf), .set_brk(rx_break),
    .rd_clr(err_rd), .err_q(err_status)
  );

  always_comb begin
    rdy_d  = rdy_q;
    hold_d = hold_q;
    evt_d  = ovf | unf;
    if (q_mode) begin
      if (flush || push_eff || pop_eff) rdy_d = (cnt_nxt != '0);
    end else begin
      if (push) begin
        rdy_d  = 1'b1;
        hold_d = pdat;
      end else if (rd_pop) begin
        rdy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      hold_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      hold_q <= hold_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    if (!q_mode)    rd_byte = hold_q;
    else if (empty) rd_byte = push ? pdat : '0;
    else            rd_byte = head;
  end

  assign stat_word  = full ? STAT_W'(9'h100) : {1'b0, 8'(cnt)};
  assign data_ready = rdy_q;
  assign err_evt    = evt_q;

  // R4
  ovf_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mode && push && !flush && full && !rd_pop) |=> (err_evt && err_status[ERR_OVR] && $stable(cnt)));

  // R5
  unf_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mode && rd_pop && !flush && empty && !push) |=> (err_evt && cnt == '0));

  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mode && push && rd_pop && !flush) |=> (!err_evt && $stable(cnt)));

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_mode && !flush) |=> (!err_evt && $stable(cnt)));
endmodule

// File: tb/tb_rxq_top.sv
`timescale 1ns/100ps
module tb_rxq_top;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_break, ctl_we, rd_pop, err_rd;
  logic [7:0] rx_byte, rd_byte;
  logic [2:0] ctl_wdata, ctl_q;
  logic tx_flush, data_ready, err_evt;
  logic [8:0] stat_word;
  logic [3:0] err_status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] q[$];
  logic [2:0] m_ctl;
  logic       m_rdy, m_evt;
  logic [3:0] m_err;
  logic [7:0] m_hold;

  always #2.5 clk = ~clk;

  rxq_top #(.DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .tx_flush(tx_flush), .rd_pop(rd_pop), .rd_byte(rd_byte),
    .stat_word(stat_word), .data_ready(data_ready), .err_rd(err_rd),
    .err_status(err_status), .err_evt(err_evt)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, logic [7:0] d, bit b, bit p, bit er, bit we, logic [2:0] wd);
    bit push, ovf, unf;
    logic [7:0] pd;
    int exp_stat;
    rx_valid = v; rx_byte = d; rx_break = b; rd_pop = p;
    err_rd = er; ctl_we = we; ctl_wdata = wd;
    #1;
    push = v | b;
    pd = b ? 8'h00 : d;
    exp_stat = (q.size() == DEP) ? 'h100 : q.size();
    chk("R3 stat_word", stat_word, exp_stat);
    chk("R9/R10 data_ready", data_ready, m_rdy);
    chk("R8 err_status", err_status, m_err);
    chk("R11 ctl_q", ctl_q, m_ctl);
    chk("R11 tx_flush", tx_flush, m_ctl[2]);
    if (p && !m_ctl[1]) begin
      if (!m_ctl[0])          chk("R10 rd_byte", rd_byte, m_hold);
      else if (q.size() == 0) chk(push ? "R6 rd_byte bypass" : "R5 rd_byte underflow", rd_byte, push ? pd : 0);
      else                    chk("R2 rd_byte", rd_byte, q[0]);
    end
    @(posedge clk);
    ovf = 0; unf = 0;
    if (m_ctl[1]) q.delete();
    else if (m_ctl[0]) begin
      if (push && p) begin
        if (q.size() != 0) begin void'(q.pop_front()); q.push_back(pd); end
      end else if (p) begin
        if (q.size() == 0) unf = 1; else void'(q.pop_front());
      end else if (push) begin
        if (q.size() == DEP) ovf = 1; else q.push_back(pd);
      end
    end
    if (m_ctl[0]) begin
      if (m_ctl[1] || push || p) m_rdy = (q.size() != 0);
    end else begin
      if (push) begin m_rdy = 1; m_hold = pd; end
      else if (p) m_rdy = 0;
    end
    if (er) m_err = 0;
    if (ovf) m_err[0] = 1;
    if (b)   m_err[3] = 1;
    m_evt = ovf | unf;
    if (we) m_ctl = wd; else m_ctl[2:1] = 2'b00;
    @(negedge clk);
    chk("R4/R5/R6 err_evt", err_evt, m_evt);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rx(logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
  task automatic rd(); cyc(0, 0, 0, 1, 0, 0, 0); endtask
  task automatic wctl(logic [2:0] w); cyc(0, 0, 0, 0, 0, 1, w); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_byte = 0; rx_break = 0; rd_pop = 0;
    err_rd = 0; ctl_we = 0; ctl_wdata = 0;
    m_ctl = 0; m_rdy = 0; m_evt = 0; m_err = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 stat", stat_word, 0);
    chk("R1 ready", data_ready, 0);
    chk("R1 err", err_status, 0);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 evt", err_evt, 0);
    idle();
    // R10 holding mode
    rx(8'h11); rx(8'h22); rd(); rd();
    cyc(1, 8'h33, 0, 1, 0, 0, 0);  // read and receive together: ready stays
    rd();
    // R11 enable queue mode
    wctl(3'b001);
    rx(8'hA1); rx(8'hA2); rx(8'hA3);
    rd(); rd(); rd();   // R2 order, R9 ready clears on last
    rd();               // R5 underflow
    // R6 empty bypass
    cyc(1, 8'h5E, 0, 1, 0, 0, 0);
    // fill to full, R3
    for (int i = 0; i < DEP; i++) rx(8'(8'h40 + i));
    rx(8'hEE);          // R4 overflow
    cyc(1, 8'h77, 0, 1, 0, 0, 0);  // R6 at full
    cyc(0, 0, 0, 0, 1, 0, 0);      // R8 read clears
    idle();
    for (int i = 0; i < DEP + 1; i++) rd();
    // R7 break beats valid
    cyc(1, 8'hFF, 1, 0, 0, 0, 0);
    rd();
    // R8 read racing break
    cyc(0, 0, 1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    idle();
    // R11 flush during traffic
    rx(8'h01); rx(8'h02);
    wctl(3'b011);
    cyc(1, 8'h03, 0, 1, 0, 0, 0);
    idle(); rd();
    wctl(3'b101); idle();
    // wraparound and mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 55, 8'($urandom), r == 7, ($urandom_range(0, 99) < 45),
          ($urandom_range(0, 9) == 0), (r == 99),
          (r == 99) ? {2'($urandom), 1'b1} : 3'b000);
    end
    wctl(3'b000);
    for (int k = 0; k < 200; k++)
      cyc($urandom_range(0, 1), 8'($urandom), 0, $urandom_range(0, 1), 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule